// File: doc/BRIEF.md
# Queue Pair Doorbell, Fetch and Completion Engine

This block is the controller side of a set of paired submission and completion queues kept in host memory. The host issues work by placing a 64-byte command in a submission queue and then making a single register write: the new tail index goes to that queue's doorbell. The engine tracks head and tail pointers for every queue and picks one non-empty submission queue. It then reads only that queue's next entry through a 32-bit memory read port and streams the sixteen words straight to a command execution port. No command is read ahead, so the engine keeps no buffer of fetched commands.

When the execution side reports a finished command, the engine builds a 16-byte completion entry. It writes the entry as four words into the paired completion queue and then pulses an interrupt request carrying the queue number. The host gives completion slots back by writing the completion queue head doorbell. The engine refuses new results for a completion queue that has no free slot.

Each queue pair has its own base addresses and its own entry count, taken from static configuration inputs. Queue pair 0 is the admin pair. Pairs 1 and up carry I/O.

Top module: `qpair_engine`

## Requirements
- R1: After reset, rdReq, wrReq, irq and cmdValid are low, all queues are empty, and cplReady is high for every queue.
- R2: No read is requested while every submission queue has head equal to doorbell tail. Once a tail doorbell write makes a queue non-empty, a single read request is issued at address sqBase[q] + head*64. It is held until rdAck.
- R3: A fetched command is delivered as 16 cmdValid words in read order, with cmdQid set to the source queue and cmdLast set on the 16th word only.
- R4: A submission head moves up by one after each delivered command. It wraps to 0 after the entry at index qLast[q], where qLast is the entry count minus one.
- R5: Whenever queue 0 is non-empty at a selection point, queue 0 is fetched before any I/O queue.
- R6: I/O queues are served round-robin, starting after the I/O queue that was served last. After reset the first I/O queue served is queue 1.
- R7: An accepted completion is written as four word writes, for word index k = 0 to 3, at cqBase[q] + tail*16 + 4k. Each write is held until wrAck. Words 0 and 1 are zero. Word 2 holds the submission queue ID in bits 31:16 and that queue's head at acceptance in bits 15:0.
- R8: Word 3 holds the status in bits 31:17, the phase bit in bit 16 and the command ID in bits 15:0. The phase bit starts at 1 for every completion queue and inverts each time that queue's tail wraps to 0.
- R9: A completion queue is full when advancing its tail would make it equal to its head. While the queue selected by cplQid is full, cplReady stays low and nothing is written. A head doorbell write frees the slots.
- R10: irq pulses for exactly one cycle, with irqVec equal to the queue, in the cycle after the last word of a completion is acknowledged. There is no irq in any other cycle, including while posting is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbWrEn | input | 1 | Doorbell write strobe |
| dbQid | input | 2 | Queue pair addressed by the doorbell write |
| dbIsCq | input | 1 | 1 = completion head doorbell, 0 = submission tail doorbell |
| dbValue | input | 4 | New tail or head index |
| sqBase | input | 128 | Submission queue base address per pair, pair q at bits 32q+31:32q |
| cqBase | input | 128 | Completion queue base address per pair, same packing |
| qLast | input | 16 | Entry count minus one per pair, pair q at bits 4q+3:4q |
| rdReq | output | 1 | Command read request |
| rdAddr | output | 32 | Byte address of the command entry |
| rdAck | input | 1 | Read request accepted |
| rdValid | input | 1 | Read data word valid |
| rdData | input | 32 | Read data word |
| cmdValid | output | 1 | Command word valid toward execution |
| cmdLast | output | 1 | Last word of the command |
| cmdQid | output | 2 | Submission queue of the command |
| cmdWord | output | 32 | Command word |
| cplValid | input | 1 | Completion result offered |
| cplReady | output | 1 | Completion result accepted this cycle when valid |
| cplQid | input | 2 | Queue pair of the result |
| cplCid | input | 16 | Command ID of the result |
| cplStatus | input | 15 | Status of the result |
| wrReq | output | 1 | Completion word write request |
| wrAddr | output | 32 | Byte address of the word |
| wrData | output | 32 | Completion word |
| wrAck | input | 1 | Word write accepted |
| irq | output | 1 | Interrupt request pulse |
| irqVec | output | 2 | Queue pair of the interrupt |

## Verification
The properties assume that the host never writes a tail index beyond qLast, so a doorbell never implies more entries than the ring holds. They also assume the memory side answers each read acknowledge with exactly sixteen data words and never sends data unasked. The bench honours both assumptions: it writes only in-range indices, and its read responder sends one acknowledge followed by a counted burst of sixteen words. Completion results are offered only with a valid queue number, and the results are held until accepted.

// File: rtl/qe_pkg.sv
package qe_pkg;
  localparam int CMD_BYTES = 64;
  localparam int CPL_WORDS = 4;
  localparam int CPL_BYTES = CPL_WORDS * 4;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA} fetch_state_t;
  typedef enum logic       {C_IDLE, C_WRITE}        cpl_state_t;

  typedef struct packed {
    logic       headAdv;
    logic       tailAdv;
    logic       cplLatch;
    logic [1:0] cplWord;
  } qe_strobe_t;
endpackage

// File: rtl/qe_datapath.sv
module qe_datapath
  import qe_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int DEPTH_W = 4,
  parameter int ADDR_W  = 32,
  parameter int QID_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dbWrEn,
  input  logic [QID_W-1:0]          dbQid,
  input  logic                      dbIsCq,
  input  logic [DEPTH_W-1:0]        dbValue,
  input  logic [NUM_Q*ADDR_W-1:0]   sqBase,
  input  logic [NUM_Q*ADDR_W-1:0]   cqBase,
  input  logic [NUM_Q*DEPTH_W-1:0]  qLast,
  input  qe_strobe_t                strobe,
  input  logic [QID_W-1:0]          fetchQ,
  input  logic [QID_W-1:0]          cplQ,
  input  logic [15:0]               cplCid,
  input  logic [14:0]               cplStatus,
  output logic [NUM_Q-1:0]          sqPending,
  output logic [NUM_Q-1:0]          cqFull,
  output logic [ADDR_W-1:0]         rdAddr,
  output logic [ADDR_W-1:0]         wrAddr,
  output logic [31:0]               wrData
);
  localparam int CMD_SH = $clog2(CMD_BYTES);
  localparam int CPL_SH = $clog2(CPL_BYTES);

  logic [DEPTH_W-1:0] sqHead [NUM_Q];
  logic [DEPTH_W-1:0] sqTail [NUM_Q];
  logic [DEPTH_W-1:0] cqHead [NUM_Q];
  logic [DEPTH_W-1:0] cqTail [NUM_Q];
  logic               cqPhase[NUM_Q];

  logic [15:0]        cidR;
  logic [14:0]        statusR;
  logic [DEPTH_W-1:0] headR;
  logic               phaseR;

  function automatic logic [DEPTH_W-1:0] bump(input logic [DEPTH_W-1:0] p,
                                              input logic [DEPTH_W-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic [DEPTH_W-1:0] lastIdx;
    assign lastIdx = qLast[q*DEPTH_W +: DEPTH_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sqHead[q]  <= '0;
        sqTail[q]  <= '0;
        cqHead[q]  <= '0;
        cqTail[q]  <= '0;
        cqPhase[q] <= 1'b1;
      end else begin
        if (dbWrEn && dbQid == QID_W'(q)) begin
          if (dbIsCq) cqHead[q] <= dbValue;
          else        sqTail[q] <= dbValue;
        end
        if (strobe.headAdv && fetchQ == QID_W'(q))
          sqHead[q] <= bump(sqHead[q], lastIdx);
        if (strobe.tailAdv && cplQ == QID_W'(q)) begin
          cqTail[q] <= bump(cqTail[q], lastIdx);
          if (cqTail[q] == lastIdx) cqPhase[q] <= ~cqPhase[q];
        end
      end
    end

    assign sqPending[q] = (sqHead[q] != sqTail[q]);
    assign cqFull[q]    = (bump(cqTail[q], lastIdx) == cqHead[q]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cidR    <= '0;
      statusR <= '0;
      headR   <= '0;
      phaseR  <= 1'b0;
    end else if (strobe.cplLatch) begin
      cidR    <= cplCid;
      statusR <= cplStatus;
      headR   <= sqHead[cplQ];
      phaseR  <= cqPhase[cplQ];
    end
  end

  assign rdAddr = sqBase[fetchQ*ADDR_W +: ADDR_W]
                + (ADDR_W'(sqHead[fetchQ]) << CMD_SH);
  assign wrAddr = cqBase[cplQ*ADDR_W +: ADDR_W]
                + (ADDR_W'(cqTail[cplQ]) << CPL_SH)
                + (ADDR_W'(strobe.cplWord) << 2);

  always_comb begin
    case (strobe.cplWord)
      2'd2:    wrData = {16'(cplQ), 16'(headR)};
      2'd3:    wrData = {statusR, phaseR, cidR};
      default: wrData = '0;
    endcase
  end
endmodule

// File: rtl/qe_control.sv
module qe_control
  import qe_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int QID_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_Q-1:0] sqPending,
  input  logic [NUM_Q-1:0] cqFull,
  input  logic             rdAck,
  input  logic             rdValid,
  input  logic             cplValid,
  input  logic [QID_W-1:0] cplQidIn,
  input  logic             wrAck,
  output qe_strobe_t       strobe,
  output logic [QID_W-1:0] fetchQ,
  output logic [QID_W-1:0] cplQ,
  output logic             rdReq,
  output logic             cmdValid,
  output logic             cmdLast,
  output logic             cplReady,
  output logic             wrReq,
  output logic             irq,
  output logic [QID_W-1:0] irqVec
);
  localparam int CMD_WORDS = CMD_BYTES / 4;
  localparam int WCNT_W    = $clog2(CMD_WORDS);

  fetch_state_t      fState;
  cpl_state_t        cState;
  logic [QID_W-1:0]  selQ, lastIo, cplQR;
  logic [WCNT_W-1:0] wordCnt;
  logic [1:0]        wordIdx;
  logic              pickValid;
  logic [QID_W-1:0]  pickQ;
  int                idx;

  // Admin queue first, then round-robin over I/O queues after lastIo.
  always_comb begin
    pickValid = 1'b0;
    pickQ     = '0;
    idx       = 0;
    if (sqPending[0]) begin
      pickValid = 1'b1;
    end else begin
      for (int k = 1; k < NUM_Q; k++) begin
        idx = ((int'(lastIo) - 1 + k) % (NUM_Q - 1)) + 1;
        if (!pickValid && sqPending[idx]) begin
          pickValid = 1'b1;
          pickQ     = QID_W'(idx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fState  <= F_IDLE;
      selQ    <= '0;
      lastIo  <= QID_W'(NUM_Q - 1);
      wordCnt <= '0;
    end else begin
      case (fState)
        F_IDLE: if (pickValid) begin
          selQ   <= pickQ;
          if (pickQ != '0) lastIo <= pickQ;
          fState <= F_REQ;
        end
        F_REQ: if (rdAck) begin
          wordCnt <= '0;
          fState  <= F_DATA;
        end
        F_DATA: if (rdValid) begin
          wordCnt <= wordCnt + 1'b1;
          if (wordCnt == WCNT_W'(CMD_WORDS - 1)) fState <= F_IDLE;
        end
        default: fState <= F_IDLE;
      endcase
    end
  end

  assign rdReq    = (fState == F_REQ);
  assign cmdValid = (fState == F_DATA) && rdValid;
  assign cmdLast  = cmdValid && (wordCnt == WCNT_W'(CMD_WORDS - 1));
  assign fetchQ   = selQ;

  assign cplReady = (cState == C_IDLE) && !cqFull[cplQidIn];
  assign cplQ     = (cState == C_IDLE) ? cplQidIn : cplQR;
  assign wrReq    = (cState == C_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cState  <= C_IDLE;
      cplQR   <= '0;
      wordIdx <= '0;
      irq     <= 1'b0;
      irqVec  <= '0;
    end else begin
      irq <= 1'b0;
      case (cState)
        C_IDLE: if (cplValid && cplReady) begin
          cplQR   <= cplQidIn;
          wordIdx <= '0;
          cState  <= C_WRITE;
        end
        C_WRITE: if (wrAck) begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == 2'(CPL_WORDS - 1)) begin
            irq    <= 1'b1;
            irqVec <= cplQR;
            cState <= C_IDLE;
          end
        end
        default: cState <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.headAdv  = cmdLast;
    strobe.cplLatch = (cState == C_IDLE) && cplValid && cplReady;
    strobe.tailAdv  = wrReq && wrAck && (wordIdx == 2'(CPL_WORDS - 1));
    strobe.cplWord  = wordIdx;
  end
endmodule

// File: rtl/qpair_engine.sv
module qpair_engine
  import qe_pkg::*;
#(
  parameter  int NUM_Q   = 4,
  parameter  int DEPTH_W = 4,
  parameter  int ADDR_W  = 32,
  localparam int QID_W   = $clog2(NUM_Q)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dbWrEn,
  input  logic [QID_W-1:0]         dbQid,
  input  logic                     dbIsCq,
  input  logic [DEPTH_W-1:0]       dbValue,
  input  logic [NUM_Q*ADDR_W-1:0]  sqBase,
  input  logic [NUM_Q*ADDR_W-1:0]  cqBase,
  input  logic [NUM_Q*DEPTH_W-1:0] qLast,
  output logic                     rdReq,
  output logic [ADDR_W-1:0]        rdAddr,
  input  logic                     rdAck,
  input  logic                     rdValid,
  input  logic [31:0]              rdData,
  output logic                     cmdValid,
  output logic                     cmdLast,
  output logic [QID_W-1:0]         cmdQid,
  output logic [31:0]              cmdWord,
  input  logic                     cplValid,
  output logic                     cplReady,
  input  logic [QID_W-1:0]         cplQid,
  input  logic [15:0]              cplCid,
  input  logic [14:0]              cplStatus,
  output logic                     wrReq,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [31:0]              wrData,
  input  logic                     wrAck,
  output logic                     irq,
  output logic [QID_W-1:0]         irqVec
);
  qe_strobe_t       strobe;
  logic [NUM_Q-1:0] sqPending, cqFull;
  logic [QID_W-1:0] fetchQ, cplQ;

  qe_control #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_ctrl (
    .clk, .rstN, .sqPending, .cqFull, .rdAck, .rdValid, .cplValid,
    .cplQidIn(cplQid), .wrAck, .strobe, .fetchQ, .cplQ, .rdReq, .cmdValid,
    .cmdLast, .cplReady, .wrReq, .irq, .irqVec
  );

  qe_datapath #(.NUM_Q(NUM_Q), .DEPTH_W(DEPTH_W), .ADDR_W(ADDR_W), .QID_W(QID_W)) u_dp (
    .clk, .rstN, .dbWrEn, .dbQid, .dbIsCq, .dbValue, .sqBase, .cqBase, .qLast,
    .strobe, .fetchQ, .cplQ, .cplCid, .cplStatus, .sqPending, .cqFull,
    .rdAddr, .wrAddr, .wrData
  );

  assign cmdQid  = fetchQ;
  assign cmdWord = rdData;
endmodule

// File: rtl/qpair_engine_chk.sv
module qpair_engine_chk #(
  parameter int NUM_Q  = 4,
  parameter int ADDR_W = 32,
  parameter int QID_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              wrAck,
  input logic              irq,
  input logic              cplValid,
  input logic              cplReady,
  input logic [QID_W-1:0]  cplQid,
  input logic [NUM_Q-1:0]  cqFull,
  input logic [NUM_Q-1:0]  sqPending,
  input logic [QID_W-1:0]  fetchQ
);
  // R2: a new read request only targets a queue holding work
  a_r2_fetch_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdReq) |-> sqPending[fetchQ]);

  // R2: read request and address hold until acknowledged
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(rdAddr));

  // R7: write request, address and data hold until acknowledged
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq && $stable(wrAddr) && $stable(wrData));

  // R9: a result is never taken for a queue with no free slot
  a_r9_no_post_full: assert property (@(posedge clk) disable iff (!rstN)
    cplValid && cplReady |-> !cqFull[cplQid]);

  // R10: an interrupt follows an acknowledged completion write
  a_r10_irq_after_write: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(wrReq && wrAck));

  // R10: the interrupt is a single-cycle pulse
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

bind qpair_engine qpair_engine_chk #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .QID_W(QID_W)) u_chk (.*);

// File: tb/sim_qpair_engine.sv
module sim_qpair_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SMP = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbWrEn = 1'b0, dbIsCq = 1'b0;
  logic [1:0]  dbQid = '0;
  logic [3:0]  dbValue = '0;
  logic [127:0] sqBase = {32'h4000, 32'h3000, 32'h2000, 32'h1000};
  logic [127:0] cqBase = {32'h8300, 32'h8200, 32'h8100, 32'h8000};
  logic [15:0]  qLast  = {4'd15, 4'd3, 4'd7, 4'd3};
  logic        rdReq, rdAck = 1'b0, rdValid = 1'b0;
  logic [31:0] rdAddr, rdData = '0;
  logic        cmdValid, cmdLast;
  logic [1:0]  cmdQid;
  logic [31:0] cmdWord;
  logic        cplValid = 1'b0, cplReady;
  logic [1:0]  cplQid = '0;
  logic [15:0] cplCid = '0;
  logic [14:0] cplStatus = '0;
  logic        wrReq, wrAck = 1'b0, irq;
  logic [31:0] wrAddr, wrData;
  logic [1:0]  irqVec;

  qpair_engine u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0;
  logic [31:0] fAddr [64];
  int          nFetch = 0;
  logic [1:0]  cQid [64];
  int          nCmd = 0, wordCnt = 0;
  logic [31:0] wLogA [64], wLogD [64];
  int          nWr = 0, nIrq = 0;
  logic [1:0]  lastIrqVec = '0;
  logic        rdBusy = 1'b0;
  int          rdCnt = 0;
  logic [31:0] rdBaseA = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory read responder: one ack then a 16-word burst
  always @(negedge clk) begin
    if (!rstN) begin
      rdAck = 1'b0; rdValid = 1'b0; rdBusy = 1'b0; rdCnt = 0;
    end else if (rdBusy) begin
      rdAck = 1'b0;
      if (rdCnt < 16) begin
        rdValid = 1'b1;
        rdData  = {rdBaseA[15:0], 12'h0, 4'(rdCnt)};
        rdCnt++;
      end else begin
        rdValid = 1'b0;
        rdBusy  = 1'b0;
      end
    end else if (rdReq) begin
      rdAck = 1'b1; rdBusy = 1'b1; rdCnt = 0; rdBaseA = rdAddr;
      fAddr[nFetch] = rdAddr; nFetch++;
    end else begin
      rdAck = 1'b0; rdValid = 1'b0;
    end
  end

  // Write responder and interrupt log
  always @(negedge clk) begin
    wrAck = wrReq;
    if (wrReq) begin wLogA[nWr] = wrAddr; wLogD[nWr] = wrData; nWr++; end
    if (irq) begin nIrq++; lastIrqVec = irqVec; end
  end

  // Command port monitor
  always @(negedge clk) begin
    #SMP;
    if (rstN && cmdValid) begin
      check(cmdWord == {rdBaseA[15:0], 12'h0, 4'(wordCnt)}, "R3 word", cmdWord,
            {rdBaseA[15:0], 12'h0, 4'(wordCnt)});
      wordCnt++;
      if (cmdLast) begin
        check(wordCnt == 16, "R3 words per command", 32'(wordCnt), 32'd16);
        cQid[nCmd] = cmdQid; nCmd++; wordCnt = 0;
      end
    end
  end

  task automatic ringDb(input logic [1:0] q, input logic isCq, input logic [3:0] v);
    @(negedge clk);
    dbWrEn = 1'b1; dbQid = q; dbIsCq = isCq; dbValue = v;
    @(negedge clk);
    dbWrEn = 1'b0;
  endtask

  typedef struct packed {
    logic        headWr;
    logic [3:0]  headVal;
    logic [15:0] cid;
    logic [14:0] status;
    logic [31:0] expAddr;
    logic [31:0] expDw3;
    logic        fullAfter;
  } row_t;

  localparam row_t ROWS [5] = '{
    '{1'b0, 4'd0, 16'h0011, 15'd0, 32'h8200, 32'h00010011, 1'b0},
    '{1'b0, 4'd0, 16'h0022, 15'd5, 32'h8210, 32'h000B0022, 1'b0},
    '{1'b0, 4'd0, 16'h0033, 15'd0, 32'h8220, 32'h00010033, 1'b1},
    '{1'b1, 4'd2, 16'h0044, 15'd0, 32'h8230, 32'h00010044, 1'b0},
    '{1'b0, 4'd0, 16'h0055, 15'd0, 32'h8200, 32'h00000055, 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #SMP;
    // R1: reset state
    check(!rdReq && !wrReq, "R1 no requests", {30'b0, rdReq, wrReq}, 32'h0);
    check(!irq && !cmdValid, "R1 no irq or cmd", {30'b0, irq, cmdValid}, 32'h0);
    check(cplReady, "R1 ready", 32'(cplReady), 32'h1);

    // Completion table on queue pair 2 (4 entries)
    for (int r = 0; r < 5; r++) begin
      int w0, i0;
      if (ROWS[r].headWr) ringDb(2'd2, 1'b1, ROWS[r].headVal);
      w0 = nWr; i0 = nIrq;
      @(negedge clk);
      cplValid = 1'b1; cplQid = 2'd2; cplCid = ROWS[r].cid; cplStatus = ROWS[r].status;
      #SMP;
      check(cplReady, "R9 ready with free slot", 32'(cplReady), 32'h1);
      @(negedge clk);
      cplValid = 1'b0;
      repeat (8) @(negedge clk);
      check(nWr == w0 + 4, "R7 word count", 32'(nWr - w0), 32'd4);
      for (int k = 0; k < 4; k++)
        check(wLogA[w0+k] == ROWS[r].expAddr + 32'(4*k), "R7 address", wLogA[w0+k],
              ROWS[r].expAddr + 32'(4*k));
      check(wLogD[w0] == 0 && wLogD[w0+1] == 0, "R7 words 0 and 1", wLogD[w0] | wLogD[w0+1], 32'h0);
      check(wLogD[w0+2] == 32'h00020000, "R7 word 2", wLogD[w0+2], 32'h00020000);
      check(wLogD[w0+3] == ROWS[r].expDw3, "R8 word 3 phase", wLogD[w0+3], ROWS[r].expDw3);
      check(nIrq == i0 + 1 && lastIrqVec == 2'd2, "R10 irq", 32'(nIrq - i0), 32'd1);
      if (ROWS[r].fullAfter) begin
        w0 = nWr; i0 = nIrq;
        @(negedge clk);
        cplValid = 1'b1; cplQid = 2'd2; cplCid = 16'hFFFF;
        repeat (6) @(negedge clk);
        #SMP;
        check(!cplReady, "R9 ready low when full", 32'(cplReady), 32'h0);
        check(nWr == w0, "R9 no write when full", 32'(nWr - w0), 32'h0);
        check(nIrq == i0, "R10 no irq while stalled", 32'(nIrq - i0), 32'h0);
        cplQid = 2'd1;
        #1;
        check(cplReady, "R9 other queue still ready", 32'(cplReady), 32'h1);
        cplValid = 1'b0;
      end
    end

    // R2: empty queues produce no fetch
    repeat (20) @(negedge clk);
    check(nFetch == 0, "R2 no fetch when empty", 32'(nFetch), 32'h0);

    // R2/R3/R4: two commands on queue 1
    ringDb(2'd1, 1'b0, 4'd2);
    repeat (50) @(negedge clk);
    check(nFetch == 2, "R2 fetch count", 32'(nFetch), 32'd2);
    check(fAddr[0] == 32'h2000, "R2 first address", fAddr[0], 32'h2000);
    check(fAddr[1] == 32'h2040, "R4 head advance", fAddr[1], 32'h2040);
    check(nCmd == 2 && cQid[0] == 2'd1 && cQid[1] == 2'd1, "R3 cmdQid", 32'(cQid[1]), 32'd1);

    // R5/R6: admin first, then round-robin over I/O queues
    ringDb(2'd1, 1'b0, 4'd3);
    ringDb(2'd3, 1'b0, 4'd1);
    ringDb(2'd2, 1'b0, 4'd1);
    ringDb(2'd0, 1'b0, 4'd1);
    repeat (100) @(negedge clk);
    check(nFetch == 6, "R5 fetch count", 32'(nFetch), 32'd6);
    check(fAddr[2] == 32'h2080, "R6 current queue finishes", fAddr[2], 32'h2080);
    check(fAddr[3] == 32'h1000, "R5 admin first", fAddr[3], 32'h1000);
    check(fAddr[4] == 32'h3000, "R6 next after queue 1", fAddr[4], 32'h3000);
    check(fAddr[5] == 32'h4000, "R6 then queue 3", fAddr[5], 32'h4000);
    check(cQid[3] == 2'd0 && cQid[4] == 2'd2 && cQid[5] == 2'd3, "R6 cmdQid order",
          {26'b0, cQid[3], cQid[4], cQid[5]}, 32'h0B);

    // R4: wrap of admin queue (4 entries, head at 1)
    ringDb(2'd0, 1'b0, 4'd0);
    repeat (70) @(negedge clk);
    ringDb(2'd0, 1'b0, 4'd1);
    repeat (30) @(negedge clk);
    check(nFetch == 10, "R4 fetch count", 32'(nFetch), 32'd10);
    check(fAddr[6] == 32'h1040 && fAddr[7] == 32'h1080, "R4 admin entries", fAddr[7], 32'h1080);
    check(fAddr[8] == 32'h10C0, "R4 last entry", fAddr[8], 32'h10C0);
    check(fAddr[9] == 32'h1000, "R4 wrap to 0", fAddr[9], 32'h1000);
    check(nIrq == 5, "R10 no irq without completion", 32'(nIrq), 32'd5);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule